// File: doc/BRIEF.md
# IO Address Translation Cache

This block turns 32-bit device DMA addresses into 42-bit real memory addresses. A lookup first reads a 16-entry segment cache chosen by the top four address bits. The segment entry gives a page-table base and a page-size code. From these the block forms the address of the page-table entry that would describe the page. That entry address feeds a 256-entry direct-mapped page cache. The cache slot is picked by a hash of the entry address and confirmed by a tag taken from that same address.

Software fills and inspects both caches through a register port. A page-cache entry is staged in a data register and committed by a write to the tag directory. A readback works the other way round: a directory read fetches the slot's entry into the data register. Lookups only run while three enable bits are set. Each request returns one registered result a cycle later. The result is either a hit with the real address, or a status code that names the miss or fault.

Top module: `io_xlate_cache`

## Requirements
- R1: `lkAddr[31:28]` selects a segment entry. A segment register word holds the valid bit at bit 63, the size code at 62:60, the page-table page count at 58:52 and the page-table base at 41:0. Bits 59 and 51:42 read back as zero. A lookup through an invalid segment returns status 2 (segment miss).
- R2: The page number is `lkAddr[27:0] >> (10 + 2*size)`. The entry address is the base plus `(pageNumber << 3) & 0x7FFF8`. Size codes 1, 3, 5 and 7 are legal and give 4 KB, 64 KB, 1 MB and 16 MB pages. Any other code returns status 5 (size fault).
- R3: The 8-bit cache slot index is formed from the entry address `ea`. Bits 7:6 take `ea[15:14]`. Bit i of bits 5:0 is `ea[3+i] ^ ea[17-i]`.
- R4: A directory word holds the valid bit at bit 33, `ea[41:18]` at 32:9 and `ea[11:3]` at 8:0. A lookup whose slot is invalid, or whose stored tag differs from the computed one, returns status 3 (tag miss).
- R5: A page entry word holds read permission at bit 63 and write permission at bit 62. It also holds a coherence bit at 61, ordering at 60:59, a 16-bit IO identifier at 58:43 and the real page number at 41:12. A write lookup without write permission, or a read lookup without read permission, returns status 4 (protection fault).
- R6: Writing the data register (address 0x200) changes no cache slot. A write to directory address `{2'b01, index}` stores the tag and commits the current data register value into that slot.
- R7: A read of directory address `{2'b01, index}` returns the 34-bit tag word and loads that slot's entry into the data register. A following read of 0x200 returns that entry. A read of segment address `{6'b0, seg}` returns the segment word. Read data appears on `regRdData` one cycle after `regRdEn`.
- R8: Translation runs only when three bits are all set: bit 0 of the command register (0x201), and bits 1 (enable) and 0 (software-managed) of the origin register (0x202). Otherwise every lookup returns status 0 (off).
- R9: A clean lookup returns status 1 (hit). The real address is the entry's real page number with its low `10 + 2*size` bits replaced by the same bits of `lkAddr`. `rspRealAddr` is zero for every non-hit result.
- R10: `rspValid` is high exactly in the cycle after a cycle with `lkValid` high. The result reflects cache contents from before any fill made in the request cycle.
- R11: Reset clears every segment and page-cache valid bit and all three enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkWrite | input | 1 | Request is a DMA write |
| lkAddr | input | 32 | Device DMA address |
| rspValid | output | 1 | Result valid, one cycle after request |
| rspStatus | output | 3 | 0 off, 1 hit, 2 segment miss, 3 tag miss, 4 protection fault, 5 size fault |
| rspRealAddr | output | 42 | Translated real address on hit, else zero |
| regWrEn | input | 1 | Register write strobe (wins over a read in the same cycle) |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 10 | Register address: 9:8 = 00 segment, 01 directory, 10 control |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Registered read data |

## Verification
Lookups cover all four legal page sizes. This shows that offset width and page-number shift follow the size code. Page numbers are chosen so that some hash inputs have bits 17:12 and 15:14 set, which separates a correct XOR fold from a plain slice. Two addresses in different segments land on the same slot, so a tag compare that ignores the high entry-address bits would wrongly hit. Read and write lookups run against read-only pages, and further patterns hit an invalid segment, an illegal size code and a disabled translator. Together these check the fault priority and the enable gate.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int IO_AW     = 32;
  localparam int RA_W      = 42;
  localparam int WORD_W    = 64;
  localparam int SEG_IDX_W = 4;
  localparam int SEG_N     = 1 << SEG_IDX_W;
  localparam int PTC_IDX_W = 8;
  localparam int PTC_N     = 1 << PTC_IDX_W;
  localparam int TAG_BODY_W = (RA_W - 18) + 9;
  localparam int REG_AW    = 10;

  typedef enum logic [2:0] {
    ST_OFF        = 3'd0,
    ST_HIT        = 3'd1,
    ST_SEG_MISS   = 3'd2,
    ST_TAG_MISS   = 3'd3,
    ST_PROT_FAULT = 3'd4,
    ST_SIZE_FAULT = 3'd5
  } xlStatus_e;

  typedef enum logic [1:0] {
    RS_NONE  = 2'd0,
    RS_SEG   = 2'd1,
    RS_DIR   = 2'd2,
    RS_STAGE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                 segWr;
    logic                 dirWr;
    logic                 dirRd;
    logic                 stageWr;
    rdSel_e               rdSel;
    logic [PTC_IDX_W-1:0] idx;
    logic [WORD_W-1:0]    wrData;
  } regStrobe_t;
endpackage

// File: rtl/xlc_ctrl.sv
module xlc_ctrl
  import xlc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic [WORD_W-1:0]   dpRdData,
  output regStrobe_t          strobe,
  output logic                xlateOn,
  output logic [WORD_W-1:0]   regRdData
);
  logic [1:0] region;
  logic       wrAct, rdAct, ctlRegion;
  logic       cfgWr, originWr;
  logic       cfgEn, originEn, originSw;
  logic [WORD_W-1:0] rdNext;

  assign region    = regAddr[REG_AW-1:REG_AW-2];
  assign wrAct     = regWrEn;
  assign rdAct     = regRdEn & ~regWrEn;
  assign ctlRegion = (region == 2'b10);

  always_comb begin
    strobe         = '0;
    strobe.idx     = regAddr[PTC_IDX_W-1:0];
    strobe.wrData  = regWrData;
    strobe.segWr   = wrAct && (region == 2'b00);
    strobe.dirWr   = wrAct && (region == 2'b01);
    strobe.dirRd   = rdAct && (region == 2'b01);
    strobe.stageWr = wrAct && ctlRegion && (regAddr[1:0] == 2'd0);
    case (region)
      2'b00:   strobe.rdSel = RS_SEG;
      2'b01:   strobe.rdSel = RS_DIR;
      2'b10:   strobe.rdSel = (regAddr[1:0] == 2'd0) ? RS_STAGE : RS_NONE;
      default: strobe.rdSel = RS_NONE;
    endcase
  end

  assign cfgWr    = wrAct && ctlRegion && (regAddr[1:0] == 2'd1);
  assign originWr = wrAct && ctlRegion && (regAddr[1:0] == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      originEn <= 1'b0;
      originSw <= 1'b0;
    end else begin
      if (cfgWr) cfgEn <= regWrData[0];
      if (originWr) begin
        originEn <= regWrData[1];
        originSw <= regWrData[0];
      end
    end
  end

  assign xlateOn = cfgEn & originEn & originSw;

  always_comb begin
    rdNext = '0;
    if (region != 2'b11) begin
      if (!ctlRegion || regAddr[1:0] == 2'd0) rdNext = dpRdData;
      else if (regAddr[1:0] == 2'd1)          rdNext = {{(WORD_W-1){1'b0}}, cfgEn};
      else if (regAddr[1:0] == 2'd2)          rdNext = {{(WORD_W-2){1'b0}}, originEn, originSw};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdData <= '0;
    else if (rdAct) regRdData <= rdNext;
  end

  // R6: at most one storage strobe per cycle
  p_onehot_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.segWr, strobe.dirWr, strobe.dirRd, strobe.stageWr, cfgWr, originWr}));

  // R11: enables come out of reset cleared
  p_reset_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !xlateOn);
endmodule

// File: rtl/xlc_datapath.sv
module xlc_datapath
  import xlc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic                xlateOn,
  input  logic                lkValid,
  input  logic                lkWrite,
  input  logic [IO_AW-1:0]    lkAddr,
  output logic                rspValid,
  output xlStatus_e           rspStatus,
  output logic [RA_W-1:0]     rspRealAddr,
  output logic [WORD_W-1:0]   dpRdData
);
  // segment cache
  logic [SEG_N-1:0] segValid;
  logic [2:0]       segPs   [SEG_N];
  logic [6:0]       segNnpt [SEG_N];
  logic [RA_W-1:0]  segBase [SEG_N];

  // page cache
  logic [PTC_N-1:0]      ptcValid;
  logic [TAG_BODY_W-1:0] ptcTag  [PTC_N];
  logic [WORD_W-1:0]     ptcData [PTC_N];
  logic [WORD_W-1:0]     stage;

  logic [SEG_IDX_W-1:0] segI;
  logic [SEG_IDX_W-1:0] wrSeg;
  logic [2:0]           ps;
  logic [4:0]           shiftAmt;
  logic [15:0]          pgNum;
  logic [RA_W-1:3]      ea;
  logic [PTC_IDX_W-1:0] hIdx;
  logic [TAG_BODY_W-1:0] tagBody;
  logic                 sizeOk, tagHit, protOk;
  logic [RA_W-1:0]      offMask, realAddr;
  xlStatus_e            nextStatus;

  assign wrSeg = strobe.idx[SEG_IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segValid <= '0;
      for (int i = 0; i < SEG_N; i++) begin
        segPs[i]   <= '0;
        segNnpt[i] <= '0;
        segBase[i] <= '0;
      end
    end else if (strobe.segWr) begin
      segValid[wrSeg] <= strobe.wrData[63];
      segPs[wrSeg]    <= strobe.wrData[62:60];
      segNnpt[wrSeg]  <= strobe.wrData[58:52];
      segBase[wrSeg]  <= strobe.wrData[RA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptcValid <= '0;
      stage    <= '0;
    end else begin
      if (strobe.dirWr)   ptcValid[strobe.idx] <= strobe.wrData[TAG_BODY_W];
      if (strobe.stageWr) stage <= strobe.wrData;
      else if (strobe.dirRd) stage <= ptcData[strobe.idx];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.dirWr) begin
      ptcTag[strobe.idx]  <= strobe.wrData[TAG_BODY_W-1:0];
      ptcData[strobe.idx] <= stage;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RS_SEG:   dpRdData = {segValid[wrSeg], segPs[wrSeg], 1'b0, segNnpt[wrSeg],
                            {(52-RA_W){1'b0}}, segBase[wrSeg]};
      RS_DIR:   dpRdData = {{(WORD_W-TAG_BODY_W-1){1'b0}}, ptcValid[strobe.idx], ptcTag[strobe.idx]};
      RS_STAGE: dpRdData = stage;
      default:  dpRdData = '0;
    endcase
  end

  // lookup: segment stage
  assign segI     = lkAddr[IO_AW-1:IO_AW-SEG_IDX_W];
  assign ps       = segPs[segI];
  assign sizeOk   = ps[0];
  assign shiftAmt = 5'd10 + {1'b0, ps, 1'b0};
  assign pgNum    = 16'({4'b0, lkAddr[27:0]} >> shiftAmt);
  assign ea       = segBase[segI][RA_W-1:3] + (RA_W-3)'(pgNum);

  // hashed slot index
  assign hIdx[7:6] = ea[15:14];
  for (genvar gi = 0; gi < 6; gi++) begin : g_hash
    assign hIdx[gi] = ea[3+gi] ^ ea[17-gi];
  end

  assign tagBody  = {ea[RA_W-1:18], ea[11:3]};
  assign tagHit   = ptcValid[hIdx] && (ptcTag[hIdx] == tagBody);
  assign protOk   = lkWrite ? ptcData[hIdx][62] : ptcData[hIdx][63];
  assign offMask  = (RA_W'(1) << shiftAmt) - RA_W'(1);
  assign realAddr = ({ptcData[hIdx][RA_W-1:12], 12'b0} & ~offMask)
                  | ({{(RA_W-IO_AW){1'b0}}, lkAddr} & offMask);

  always_comb begin
    if (!xlateOn)             nextStatus = ST_OFF;
    else if (!segValid[segI]) nextStatus = ST_SEG_MISS;
    else if (!sizeOk)         nextStatus = ST_SIZE_FAULT;
    else if (!tagHit)         nextStatus = ST_TAG_MISS;
    else if (!protOk)         nextStatus = ST_PROT_FAULT;
    else                      nextStatus = ST_HIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspStatus   <= ST_OFF;
      rspRealAddr <= '0;
    end else begin
      rspValid    <= lkValid;
      rspStatus   <= lkValid ? nextStatus : ST_OFF;
      rspRealAddr <= (lkValid && nextStatus == ST_HIT) ? realAddr : '0;
    end
  end

  // R10: one-cycle result latency
  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(lkValid));

  // R8: no translation while disabled
  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(xlateOn)) |-> rspStatus == ST_OFF);

  // R1: segment miss only through an invalid segment entry
  p_seg_miss_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == ST_SEG_MISS) |-> !$past(segValid[lkAddr[31:28]]));

  // R6: a directory write commits the written valid bit
  p_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirWr |=> ptcValid[$past(strobe.idx)] == $past(strobe.wrData[TAG_BODY_W]));

  // R9: address is zero on every non-hit result
  p_zero_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspStatus != ST_HIT) |-> rspRealAddr == '0);
endmodule

// File: rtl/io_xlate_cache.sv
module io_xlate_cache
  import xlc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lkValid,
  input  logic         lkWrite,
  input  logic [31:0]  lkAddr,
  output logic         rspValid,
  output logic [2:0]   rspStatus,
  output logic [41:0]  rspRealAddr,
  input  logic         regWrEn,
  input  logic         regRdEn,
  input  logic [9:0]   regAddr,
  input  logic [63:0]  regWrData,
  output logic [63:0]  regRdData
);
  regStrobe_t        strobe;
  logic              xlateOn;
  logic [WORD_W-1:0] dpRdData;
  xlStatus_e         status;

  xlc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .dpRdData  (dpRdData),
    .strobe    (strobe),
    .xlateOn   (xlateOn),
    .regRdData (regRdData)
  );

  xlc_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .xlateOn     (xlateOn),
    .lkValid     (lkValid),
    .lkWrite     (lkWrite),
    .lkAddr      (lkAddr),
    .rspValid    (rspValid),
    .rspStatus   (status),
    .rspRealAddr (rspRealAddr),
    .dpRdData    (dpRdData)
  );

  assign rspStatus = status;
endmodule

// File: tb/io_xlate_cache_tb.sv
`timescale 1ns/1ps
module io_xlate_cache_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, lkWrite = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        rspValid;
  logic [2:0]  rspStatus;
  logic [41:0] rspRealAddr;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [9:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  io_xlate_cache u_dut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        fill;
    logic [1:0]  prot;
    logic [29:0] rpn;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h2300_0123, 1'b0, 1'b1, 2'b11, 30'h0003_A5C0, 3'd1},
    '{32'h2F12_3456, 1'b1, 1'b1, 2'b11, 30'h0000_1000, 3'd1},
    '{32'h3020_3ABC, 1'b0, 1'b1, 2'b11, 30'h0ABC_DE01, 3'd1},
    '{32'h3000_1FFF, 1'b1, 1'b1, 2'b11, 30'h0000_0777, 3'd1},
    '{32'h4005_0010, 1'b1, 1'b1, 2'b10, 30'h0001_2340, 3'd4},
    '{32'h4005_FFF0, 1'b0, 1'b0, 2'b10, 30'h0001_2340, 3'd1},
    '{32'h5ABC_DEF0, 1'b0, 1'b1, 2'b11, 30'h0005_5000, 3'd1},
    '{32'h6000_0000, 1'b0, 1'b0, 2'b11, 30'h0,         3'd2},
    '{32'h7000_0000, 1'b0, 1'b0, 2'b11, 30'h0,         3'd5},
    '{32'h2500_0000, 1'b0, 1'b0, 2'b11, 30'h0,         3'd3},
    '{32'h3480_05A5, 1'b0, 1'b1, 2'b11, 30'h3FFF_FFFF, 3'd1},
    '{32'h3020_3ABC, 1'b1, 1'b0, 2'b11, 30'h0ABC_DE01, 3'd1}
  };

  function automatic logic [41:0] segBaseOf(int s);
    case (s)
      2: return 42'h100_0000_0000;
      3: return 42'h000_0040_0000;
      4: return 42'h000_0080_0000;
      5: return 42'h000_00C0_0000;
      default: return 42'h000_0100_0000;
    endcase
  endfunction

  function automatic logic [2:0] segPsOf(int s);
    case (s)
      2: return 3'd7;
      3: return 3'd1;
      4: return 3'd3;
      5: return 3'd5;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [63:0] segWord(int s);
    logic valid = (s != 6);
    return {valid, segPsOf(s), 1'b0, 7'h01, 10'b0, segBaseOf(s)};
  endfunction

  function automatic logic [41:3] calcEa(logic [31:0] a);
    int s = int'(a[31:28]);
    logic [31:0] pn = {4'b0, a[27:0]} >> (10 + 2 * int'(segPsOf(s)));
    logic [41:0] base = segBaseOf(s);
    return base[41:3] + {23'b0, pn[15:0]};
  endfunction

  function automatic logic [7:0] calcIdx(logic [41:3] ea);
    return {ea[15:14], ea[8:3] ^ {ea[12], ea[13], ea[14], ea[15], ea[16], ea[17]}};
  endfunction

  function automatic logic [63:0] calcTag(logic [41:3] ea);
    return {30'b0, 1'b1, ea[41:18], ea[11:3]};
  endfunction

  function automatic logic [63:0] calcPte(logic [1:0] prot, logic [29:0] rpn);
    return {prot, 1'b1, 2'b01, 16'h048A, 1'b0, rpn, 12'b0};
  endfunction

  function automatic logic [41:0] calcRa(logic [29:0] rpn, logic [31:0] a);
    int sh = 10 + 2 * int'(segPsOf(int'(a[31:28])));
    logic [41:0] mask = (42'd1 << sh) - 42'd1;
    return ({rpn, 12'b0} & ~mask) | ({10'b0, a} & mask);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [9:0] a, logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [9:0] a, output logic [63:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic lookup(logic [31:0] a, logic w, output logic [2:0] st, output logic [41:0] ra);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a; lkWrite = w;
    @(negedge clk);
    lkValid = 1'b0;
    chk("R10 rspValid after request", {63'b0, rspValid}, 64'd1);
    st = rspStatus; ra = rspRealAddr;
    @(negedge clk);
    chk("R10 rspValid idle", {63'b0, rspValid}, 64'd0);
  endtask

  task automatic fillEntry(logic [31:0] a, logic [1:0] prot, logic [29:0] rpn);
    logic [41:3] ea = calcEa(a);
    regWrite(10'h200, calcPte(prot, rpn));
    regWrite({2'b01, calcIdx(ea)}, calcTag(ea));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [63:0] d;
    logic [2:0]  st;
    logic [41:0] ra;
    logic [41:3] ea0;
    string req;

    repeat (3) @(negedge clk);
    chk("R11 rspValid in reset", {63'b0, rspValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    regRead(10'h201, d);
    chk("R11 command enable cleared", d, 64'd0);
    regRead(10'h202, d);
    chk("R11 origin bits cleared", d, 64'd0);

    for (int s = 2; s < 8; s++) regWrite({6'b0, 4'(s)}, segWord(s));
    for (int i = 0; i < NV; i++)
      if (VECS[i].fill) fillEntry(VECS[i].addr, VECS[i].prot, VECS[i].rpn);

    // R8: disabled, then partially enabled
    lookup(VECS[0].addr, 1'b0, st, ra);
    chk("R8 status while disabled", {61'b0, st}, 64'd0);
    regWrite(10'h201, 64'd1);
    regWrite(10'h202, 64'd2);
    lookup(VECS[0].addr, 1'b0, st, ra);
    chk("R8 status without software-managed bit", {61'b0, st}, 64'd0);
    regWrite(10'h202, 64'd3);

    // table walk
    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].addr, VECS[i].wr, st, ra);
      case (VECS[i].exp)
        3'd1: req = "R3 R9 hit";
        3'd2: req = "R1 segment miss";
        3'd3: req = "R4 tag miss";
        3'd4: req = "R5 protection fault";
        default: req = "R2 size fault";
      endcase
      chk(req, {61'b0, st}, {61'b0, VECS[i].exp});
      chk("R9 real address",
          {22'b0, ra},
          {22'b0, (VECS[i].exp == 3'd1) ? calcRa(VECS[i].rpn, VECS[i].addr) : 42'd0});
    end

    // R7 readback
    ea0 = calcEa(VECS[0].addr);
    regRead({2'b01, calcIdx(ea0)}, d);
    chk("R7 directory readback", d, calcTag(ea0));
    regRead(10'h200, d);
    chk("R7 data register readback", d, calcPte(VECS[0].prot, VECS[0].rpn));
    regRead(10'h002, d);
    chk("R1 segment readback", d, segWord(2));
    regRead(10'h006, d);
    chk("R1 invalid segment readback", d, segWord(6));

    // R6 staging alone has no effect; directory write commits
    regWrite(10'h200, calcPte(2'b11, 30'h0222_2000));
    lookup(VECS[0].addr, 1'b0, st, ra);
    chk("R6 staged only, old address", {22'b0, ra}, {22'b0, calcRa(VECS[0].rpn, VECS[0].addr)});
    regWrite({2'b01, calcIdx(ea0)}, calcTag(ea0));
    lookup(VECS[0].addr, 1'b0, st, ra);
    chk("R6 committed address", {22'b0, ra}, {22'b0, calcRa(30'h0222_2000, VECS[0].addr)});

    // R4 invalidating tag write
    regWrite({2'b01, calcIdx(ea0)}, calcTag(ea0) & ~64'h2_0000_0000);
    lookup(VECS[0].addr, 1'b0, st, ra);
    chk("R4 invalid slot", {61'b0, st}, 64'd3);

    // R11 reset clears valid bits and enables
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    lookup(VECS[2].addr, 1'b0, st, ra);
    chk("R11 disabled after reset", {61'b0, st}, 64'd0);
    regWrite(10'h201, 64'd1);
    regWrite(10'h202, 64'd3);
    lookup(VECS[2].addr, 1'b0, st, ra);
    chk("R11 segment valid cleared", {61'b0, st}, 64'd2);
    regWrite(10'h003, segWord(3));
    lookup(VECS[2].addr, 1'b0, st, ra);
    chk("R11 page cache valid cleared", {61'b0, st}, 64'd3);

    finishRun();
  end
endmodule